// File: doc/BRIEF.md
# Programmable Tick-Stream Clock Divider

The block builds a slower clock from one of several incoming tick streams. Every source is a one-cycle enable pulse in the system clock domain. A control register picks one source and a divide ratio from 1 to 64. The block then produces two outputs. The first is a one-cycle enable pulse, once per completed division period. The second is a square-wave level that tracks the same period. A stop bit halts both outputs cleanly. Software writes the register through a single-cycle write strobe and reads it back combinationally.

Parameter `NUM_SRC` sets how many sources are present: 1, 4 or 8. The control register holds these fields:
- bits [5:0]: the divisor code. The ratio is the code plus one.
- bit 8: the stop bit.
- source select: bits [7:6] when there are 4 sources, bits [14:12] when there are 8, and no select bits at all with a single source.

A state machine sequences the divider. It has three states:
- `ST_STOP`: outputs quiet, counter cleared.
- `ST_HIGH`: first half of a period, level output high.
- `ST_LOW`: second half, level output low.

It moves between them on these transitions:
- **halt**: to `ST_STOP`, from any state, whenever the stop bit is set.
- **restart**: from `ST_STOP` once the stop bit is clear, or from a running state when the select changes. It clears the counter, loads the programmed ratio, and goes to `ST_HIGH`, or to `ST_LOW` for ratio 1.
- **half**: from `ST_HIGH` to `ST_LOW` after floor(ratio/2) counted ticks.
- **wrap**: at the end of a period, from either running state. It emits the pulse, loads the pending ratio, and re-enters the first state of the next period.

Top module: `clkdiv_gen`

## Requirements
- R1: While running, `div_pulse` is asserted for one cycle, in the cycle after the tick that completes a period; a period is code+1 ticks of the selected source, where code is register bits [5:0].
- R2: While register bit 8 (stop) reads 1, `div_pulse` and `div_level` stay 0 and source ticks are not counted; bit 8 reads 0 while running.
- R3: With `NUM_SRC`=8 the source index is register bits [14:12] (bits [7:6] with 4 sources, none with 1); ticks on unselected sources never advance the divider.
- R4: A write with bit 8 set and bits [5:0] zero stores divisor code 0x3F.
- R5: A write with bit 8 set and a non-zero bits [5:0] stores that code unchanged.
- R6: A divisor write while running leaves the current period at its old ratio; the new ratio applies from the next period.
- R7: After the stop bit is cleared the count restarts from zero, and the first pulse follows exactly ratio selected ticks.
- R8: A change of source select while running restarts the count from zero on the new source with the programmed ratio.
- R9: `div_level` is 1 from a period start until floor(ratio/2) ticks have been counted, then 0 until the period ends; with ratio 1 it equals `div_pulse`.
- R10: Register bits other than [5:0], bit 8 and the select field read 0 and ignore writes.
- R11: Synchronous active-high reset gives a readback of 0x13F (code 0x3F, stop set, select 0) with both outputs 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| src_tick | input | NUM_SRC | One-cycle enable pulses, one per source |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register readback |
| div_pulse | output | 1 | One-cycle pulse per divided period |
| div_level | output | 1 | Square-wave level of the divided clock |

## Verification
The checker watches the register and output relations on every cycle:
- the divisor forcing and keeping on stop writes;
- the rule that a stopped register never holds a zero code;
- undefined bits reading zero;
- silence of both outputs while stopped.

Only the bench scenarios can show the tick-counting behaviour. That covers which tick ends a period, deferral of a divisor change to the boundary, the restart after stop or select change, and the exact high/low split of the level. The bench shows these by comparing each observed pulse with the tick a requirement-level model predicts.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    localparam int REG_W    = 32;
    localparam int CODE_W   = 6;
    localparam int RATIO_W  = CODE_W + 1;
    localparam int STOP_BIT = 8;

    typedef enum logic [1:0] {
        ST_STOP = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2
    } div_state_e;

    // Width of the source select field for a given source count.
    function automatic int sel_width(input int n);
        if (n == 8) return 3;
        if (n == 4) return 2;
        return 0;
    endfunction

    // Lowest bit position of the source select field.
    function automatic int sel_lsb(input int n);
        if (n == 8) return 12;
        if (n == 4) return 6;
        return 0;
    endfunction

    // Mask of register bits that hold state.
    function automatic logic [REG_W-1:0] defined_mask(input int n);
        logic [REG_W-1:0] m;
        m = (REG_W'(1) << STOP_BIT) | REG_W'((1 << CODE_W) - 1);
        if (sel_width(n) > 0)
            m = m | (REG_W'((1 << sel_width(n)) - 1) << sel_lsb(n));
        return m;
    endfunction

endpackage

// File: rtl/clkdiv_ctrl_reg.sv
module clkdiv_ctrl_reg
    import clkdiv_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int SEL_WK  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wdata,
    output logic [CODE_W-1:0] code_o,
    output logic              stop_o,
    output logic [SEL_WK-1:0] sel_o,
    output logic [REG_W-1:0]  rdata_o
);

    localparam int SEL_W   = sel_width(NUM_SRC);
    localparam int SEL_LSB = sel_lsb(NUM_SRC);
    localparam logic [CODE_W-1:0] CODE_ALL_ONES = '1;

    logic [CODE_W-1:0] code_q;
    logic              stop_q;
    logic [SEL_WK-1:0] sel_q;
    logic [SEL_WK-1:0] wsel;
    logic [CODE_W-1:0] wcode;
    logic              wstop;
    logic [REG_W-1:0]  sel_rd;

    generate
        if (SEL_W > 0) begin : g_sel
            assign wsel   = wdata[SEL_LSB +: SEL_W];
            assign sel_rd = REG_W'(sel_q) << SEL_LSB;
        end else begin : g_nosel
            assign wsel   = '0;
            assign sel_rd = '0;
        end
    endgenerate

    assign wstop = wdata[STOP_BIT];

    // A stopped divider must never hold a zero code.
    always_comb begin
        wcode = wdata[CODE_W-1:0];
        if (wstop && (wcode == '0))
            wcode = CODE_ALL_ONES;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= CODE_ALL_ONES;
            stop_q <= 1'b1;
            sel_q  <= '0;
        end else if (wr_en) begin
            code_q <= wcode;
            stop_q <= wstop;
            sel_q  <= wsel;
        end
    end

    always_comb begin
        rdata_o = sel_rd;
        rdata_o[CODE_W-1:0] = code_q;
        rdata_o[STOP_BIT]   = stop_q;
    end

    assign code_o = code_q;
    assign stop_o = stop_q;
    assign sel_o  = sel_q;

endmodule

// File: rtl/clkdiv_src_sel.sv
module clkdiv_src_sel #(
    parameter int NUM_SRC = 8,
    parameter int SEL_WK  = 3
) (
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [SEL_WK-1:0]  sel_i,
    output logic               tick_o
);

    generate
        if (NUM_SRC == 1) begin : g_single
            assign tick_o = src_i[0];
        end else begin : g_mux
            assign tick_o = src_i[sel_i];
        end
    endgenerate

endmodule

// File: rtl/clkdiv_core.sv
module clkdiv_core
    import clkdiv_pkg::*;
#(
    parameter int SEL_WK = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              stop_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic [SEL_WK-1:0] sel_i,
    output logic              pulse_o,
    output logic              level_o
);

    div_state_e         state_q, nxt_state;
    logic [RATIO_W-1:0] cnt_q, nxt_cnt;
    logic [RATIO_W-1:0] ratio_q, nxt_ratio;
    logic [SEL_WK-1:0]  sel_prev_q;
    logic [RATIO_W-1:0] pend_ratio;
    logic [RATIO_W-1:0] pend_half;
    logic [RATIO_W-1:0] cur_half;
    logic [RATIO_W-1:0] cnt_inc;
    div_state_e         start_state;
    logic               period_end;
    logic               pulse_q, level_q;

    assign pend_ratio  = RATIO_W'(code_i) + RATIO_W'(1);
    assign pend_half   = pend_ratio >> 1;
    assign cur_half    = ratio_q >> 1;
    assign cnt_inc     = cnt_q + RATIO_W'(1);
    assign start_state = (pend_half != '0) ? ST_HIGH : ST_LOW;

    always_comb begin
        nxt_state  = state_q;
        nxt_cnt    = cnt_q;
        nxt_ratio  = ratio_q;
        period_end = 1'b0;
        if (stop_i) begin
            // halt
            nxt_state = ST_STOP;
            nxt_cnt   = '0;
        end else if ((state_q == ST_STOP) || (sel_i != sel_prev_q)) begin
            // restart
            nxt_state = start_state;
            nxt_cnt   = '0;
            nxt_ratio = pend_ratio;
        end else if (tick_i) begin
            unique case (state_q)
                ST_HIGH, ST_LOW: begin
                    if (cnt_inc == ratio_q) begin
                        // wrap
                        period_end = 1'b1;
                        nxt_cnt    = '0;
                        nxt_ratio  = pend_ratio;
                        nxt_state  = start_state;
                    end else begin
                        nxt_cnt = cnt_inc;
                        if ((state_q == ST_HIGH) && (cnt_inc == cur_half))
                            nxt_state = ST_LOW; // half
                    end
                end
                default: begin
                    nxt_state = ST_STOP;
                end
            endcase
        end
    end

    // State register process.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_STOP;
            cnt_q      <= '0;
            ratio_q    <= RATIO_W'(1);
            sel_prev_q <= '0;
        end else begin
            state_q    <= nxt_state;
            cnt_q      <= nxt_cnt;
            ratio_q    <= nxt_ratio;
            sel_prev_q <= sel_i;
        end
    end

    // Output process.
    always_ff @(posedge clk) begin
        if (rst) begin
            pulse_q <= 1'b0;
            level_q <= 1'b0;
        end else begin
            pulse_q <= period_end;
            level_q <= (nxt_state == ST_HIGH) ||
                       (period_end && (ratio_q == RATIO_W'(1)));
        end
    end

    assign pulse_o = pulse_q;
    assign level_o = level_q;

endmodule

// File: rtl/clkdiv_gen.sv
module clkdiv_gen
    import clkdiv_pkg::*;
#(
    parameter int NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_tick,
    input  logic               reg_wr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic               div_pulse,
    output logic               div_level
);

    localparam int SEL_W  = sel_width(NUM_SRC);
    localparam int SEL_WK = (SEL_W > 0) ? SEL_W : 1;

    logic [CODE_W-1:0] code;
    logic              stop;
    logic [SEL_WK-1:0] sel;
    logic              tick;

    clkdiv_ctrl_reg #(.NUM_SRC(NUM_SRC), .SEL_WK(SEL_WK)) i_reg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_wr),
        .wdata   (reg_wdata),
        .code_o  (code),
        .stop_o  (stop),
        .sel_o   (sel),
        .rdata_o (reg_rdata)
    );

    clkdiv_src_sel #(.NUM_SRC(NUM_SRC), .SEL_WK(SEL_WK)) i_sel (
        .src_i  (src_tick),
        .sel_i  (sel),
        .tick_o (tick)
    );

    clkdiv_core #(.SEL_WK(SEL_WK)) i_core (
        .clk     (clk),
        .rst     (rst),
        .tick_i  (tick),
        .stop_i  (stop),
        .code_i  (code),
        .sel_i   (sel),
        .pulse_o (div_pulse),
        .level_o (div_level)
    );

endmodule

// File: rtl/clkdiv_checker.sv
module clkdiv_checker
    import clkdiv_pkg::*;
#(
    parameter int NUM_SRC = 8
) (
    input logic        clk,
    input logic        rst,
    input logic        reg_wr,
    input logic [31:0] reg_wdata,
    input logic [31:0] reg_rdata,
    input logic        div_pulse,
    input logic        div_level
);

    localparam logic [31:0] DEF_MASK = defined_mask(NUM_SRC);

    a_r2_stop_quiet: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata[STOP_BIT] && $past(reg_rdata[STOP_BIT])) |-> (!div_pulse && !div_level))
        else $error("R2: output active while stopped");

    a_r4_stopped_code_nonzero: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[STOP_BIT] |-> (reg_rdata[CODE_W-1:0] != '0))
        else $error("R4: zero divisor while stopped");

    a_r4_force_ones: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_wdata[STOP_BIT] && (reg_wdata[CODE_W-1:0] == '0))
        |=> (reg_rdata[CODE_W-1:0] == '1))
        else $error("R4: divisor not forced");

    a_r5_keep_code: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_wdata[STOP_BIT] && (reg_wdata[CODE_W-1:0] != '0))
        |=> (reg_rdata[CODE_W-1:0] == $past(reg_wdata[CODE_W-1:0])))
        else $error("R5: divisor altered on stop");

    a_r10_undef_zero: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata & ~DEF_MASK) == 32'd0)
        else $error("R10: undefined bits nonzero");

endmodule

bind clkdiv_gen clkdiv_checker #(.NUM_SRC(NUM_SRC)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .div_pulse (div_pulse),
    .div_level (div_level)
);

// File: tb/test_clkdiv_gen.sv
module test_clkdiv_gen;

    localparam int CLK_PERIOD = 10;
    localparam int NSRC = 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NSRC-1:0] src_tick = '0;
    logic            reg_wr = 1'b0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic            div_pulse;
    logic            div_level;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Scoreboard: expected pulse-producing tick ids.
    int exp_q[$];
    int tick_id = 0;
    int last_tick = -1;

    // Requirement-level model.
    bit m_stop = 1'b1;
    int m_code = 63;
    int m_sel = 0;
    int m_cnt = 0;
    int m_ratio = 1;

    always #(CLK_PERIOD/2) clk = ~clk;

    clkdiv_gen #(.NUM_SRC(NSRC)) i_clkdiv_gen (
        .clk       (clk),
        .rst       (rst),
        .src_tick  (src_tick),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .div_pulse (div_pulse),
        .div_level (div_level)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Monitor: pop and compare on each observed pulse.
    always @(negedge clk) begin
        if (!rst && !done && div_pulse) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R1/R3 unexpected pulse", last_tick, -1);
            end else begin
                int e;
                e = exp_q.pop_front();
                check(e == last_tick, "R1 pulse tick", last_tick, e);
            end
        end
    end

    task automatic reg_write(input logic [31:0] w);
        bit nstop;
        int ncode;
        int nsel;
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = w;
        @(negedge clk);
        reg_wr = 1'b0;
        nstop = w[8];
        ncode = int'(w[5:0]);
        nsel = int'(w[14:12]);
        if (nstop && ncode == 0) ncode = 63;
        if (!nstop && (m_stop || nsel != m_sel)) begin
            m_cnt = 0;
            m_ratio = ncode + 1;
        end
        m_stop = nstop;
        m_code = ncode;
        m_sel = nsel;
        @(negedge clk);
        @(negedge clk);
    endtask

    function automatic logic [31:0] cfg(input bit stop, input int code, input int sel);
        logic [31:0] w;
        w = '0;
        w[5:0] = 6'(code);
        w[8] = stop;
        w[14:12] = 3'(sel);
        return w;
    endfunction

    // Driver: one tick on source s, with model update.
    task automatic tick(input int s);
        @(negedge clk);
        src_tick = NSRC'(1) << s;
        tick_id++;
        last_tick = tick_id;
        if (!m_stop && s == m_sel) begin
            m_cnt++;
            if (m_cnt == m_ratio) begin
                exp_q.push_back(tick_id);
                m_cnt = 0;
                m_ratio = m_code + 1;
            end
        end
        @(negedge clk);
        src_tick = '0;
    endtask

    task automatic check_level(input bit exp, input string req);
        check(div_level == exp, req, int'(div_level), int'(exp));
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check(reg_rdata == 32'h13F, "R11 reset readback", reg_rdata, 32'h13F);
        check(!div_pulse && !div_level, "R11 outputs after reset",
              int'({div_pulse, div_level}), 0);

        // R4 / R5 / R2 stop writes
        reg_write(cfg(1, 0, 0));
        check(reg_rdata[5:0] == 6'h3F, "R4 forced code", reg_rdata[5:0], 6'h3F);
        check(reg_rdata[8] == 1'b1, "R2 stop reads set", reg_rdata[8], 1);
        reg_write(cfg(1, 5, 0));
        check(reg_rdata[5:0] == 6'd5, "R5 kept code", reg_rdata[5:0], 5);
        for (int i = 0; i < 3; i++) tick(0);
        check(!div_level, "R2 level quiet", div_level, 0);

        // R10 / R3 undefined bits, select field
        begin
            logic [31:0] w;
            w = 32'hFFFF_FFFF;
            w[8] = 1'b0;
            w[14:12] = 3'd2;
            w[5:0] = 6'd3;
            reg_write(w);
        end
        check(reg_rdata == 32'h0000_2003, "R10 undefined bits zero", reg_rdata, 32'h2003);
        check(reg_rdata[8] == 1'b0, "R2 stop reads clear", reg_rdata[8], 0);

        // R1 / R3: ratio 4 on source 2, noise on source 5
        for (int i = 0; i < 8; i++) begin
            tick(2);
            tick(5);
        end

        // R6: change ratio mid-period
        tick(2);
        tick(2);
        reg_write(cfg(0, 1, 2));
        for (int i = 0; i < 6; i++) tick(2);

        // R2 / R7: stop, then restart with ratio 3 after partial count
        tick(2);
        reg_write(cfg(1, 2, 2));
        for (int i = 0; i < 4; i++) tick(2);
        check(!div_level && !div_pulse, "R2 quiet while stopped",
              int'({div_pulse, div_level}), 0);
        reg_write(cfg(0, 2, 2));
        for (int i = 0; i < 3; i++) tick(2);

        // R8: select change mid-period
        tick(2);
        reg_write(cfg(0, 2, 6));
        tick(2);
        for (int i = 0; i < 3; i++) tick(6);

        // R9: level shape, ratio 5 then ratio 1
        reg_write(cfg(1, 4, 0));
        reg_write(cfg(0, 4, 0));
        check_level(1'b1, "R9 level at period start");
        tick(0); check_level(1'b1, "R9 level after tick 1 of 5");
        tick(0); check_level(1'b0, "R9 level after tick 2 of 5");
        tick(0); check_level(1'b0, "R9 level after tick 3 of 5");
        tick(0); check_level(1'b0, "R9 level after tick 4 of 5");
        tick(0); check_level(1'b1, "R9 level after wrap of 5");
        reg_write(cfg(1, 0, 0));
        reg_write(cfg(0, 0, 0));
        check_level(1'b0, "R9 ratio 1 idle level");
        tick(0); check_level(1'b1, "R9 ratio 1 level follows tick");
        @(negedge clk);
        check_level(1'b0, "R9 ratio 1 level drops");
        tick(0);

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R1 all expected pulses seen", exp_q.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule